// File: doc/BRIEF.md
# Pixel Threshold Event Detector

This block sits in the pixel path of an image-sensor front end and filters a raster of 12-bit unsigned samples down to a short list of candidate events. Each sample comes with a valid strobe, and a start-of-frame strobe marks the first pixel of every frame. The block tracks the row and column of every sample on its own counters. There is no input backpressure, because at most one pixel arrives per valid strobe and one pixel of work is done per strobe.

The block has two modes, selected per frame. In bias mode, each pixel is written into an internal per-pixel dark-level map at its raster address. In event mode, the stored bias is subtracted from each pixel, with the result clamped at zero. The corrected value is compared against a programmable threshold. Every pixel whose corrected value exceeds the threshold is queued, with its row and column, in a small FIFO. A processor drains the FIFO at its own pace, so it only ever sees the threshold crossings and never the raw stream.

Top module: `pixel_event_detector`

## Requirements
- R1: After reset the event FIFO is empty (`evt_valid_o` = 0), the overflow flag is 0 and every bias map entry is 0, so a first event-mode frame compares raw pixel values.
- R2: Pixels that arrive after reset but before the first start-of-frame are ignored: they produce no event and do not alter the bias map.
- R3: A pixel with `sof_i` = 1 is at row 0, column 0. Each later accepted pixel advances the column. After column COLS-1 the column returns to 0 and the row increments, and after the last row the row returns to 0. A new start-of-frame restarts at the origin from any position.
- R4: `mode_bias_i` is sampled only on the start-of-frame pixel (1 = bias mode, 0 = event mode) and holds for the whole frame. In bias mode each pixel overwrites its map entry and no event is produced.
- R5: In event mode the corrected value is the pixel minus its bias, or 0 when the bias is larger. An event is produced only when the corrected value is strictly greater than `thresh_i`.
- R6: Events leave the FIFO in raster order. The head entry is shown on `evt_row_o`, `evt_col_o` and `evt_val_o` (the corrected value) while `evt_valid_o` = 1, and a cycle with `evt_rd_i` = 1 removes it.
- R7: An event that arrives while the FIFO holds FIFO_DEPTH entries is dropped and sets `ovf_o`. `ovf_o` stays set until a cycle with `ovf_clr_i` = 1, and if a drop and a clear occur in the same cycle, the flag stays set.
- R8: An event from a pixel accepted on a clock edge is visible at the FIFO output right after that edge when the FIFO was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid_i | input | 1 | Pixel sample strobe |
| sof_i | input | 1 | First pixel of a frame (qualified by `pix_valid_i`) |
| pix_data_i | input | 12 | Unsigned pixel sample |
| mode_bias_i | input | 1 | 1 = bias mode, 0 = event mode; sampled at start-of-frame |
| thresh_i | input | 12 | Event threshold on the corrected value |
| evt_rd_i | input | 1 | Remove the head entry of the event FIFO |
| ovf_clr_i | input | 1 | Clear the sticky overflow flag |
| evt_valid_o | output | 1 | Event FIFO is not empty |
| evt_row_o | output | 10 | Row of the head event |
| evt_col_o | output | 10 | Column of the head event |
| evt_val_o | output | 12 | Corrected value of the head event |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bound checker watches the following on every cycle:
- the position counters stay inside the frame geometry, and the column steps forward after a start-of-frame;
- no event is produced in bias mode or before the first start-of-frame;
- every queued event's raw pixel exceeds the threshold;
- the overflow flag is sticky and is set by a drop;
- the FIFO head holds still while it is not read.

Only the bench scenarios can show that the bias map holds the right values, that the saturating subtraction and the strict comparison give exactly the expected event set, and that events come out in raster order with the right coordinates. They can also show that a mode change in mid-frame has no effect and that a drop outweighs a same-cycle clear.

// File: rtl/pxd_pkg.sv
// Shared constants and the event record for the pixel event detector.
// Assumes fixed 12-bit samples and 10-bit coordinates.
package pxd_pkg;
    localparam int PXD_PIX_W   = 12;
    localparam int PXD_COORD_W = 10;

    typedef struct packed {
        logic [PXD_COORD_W-1:0] row;
        logic [PXD_COORD_W-1:0] col;
        logic [PXD_PIX_W-1:0]   val;
    } pxd_event_t;
endpackage

// File: rtl/pxd_raster_counter.sv
// Raster position tracker. Gives the effective row, column and mode of the
// current pixel: the origin and the live mode input on a start-of-frame,
// the registered state otherwise. Accepts nothing until the first
// start-of-frame. Assumes COLS >= 2, ROWS >= 2, both <= 1024.
module pxd_raster_counter
    import pxd_pkg::*;
#(
    parameter int COLS = 16,
    parameter int ROWS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid_i,
    input  logic                   sof_i,
    input  logic                   mode_i,
    output logic                   active_o,
    output logic                   mode_o,
    output logic [PXD_COORD_W-1:0] row_o,
    output logic [PXD_COORD_W-1:0] col_o
);
    localparam logic [PXD_COORD_W-1:0] LAST_COL = PXD_COORD_W'(COLS - 1);
    localparam logic [PXD_COORD_W-1:0] LAST_ROW = PXD_COORD_W'(ROWS - 1);

    logic                   active_q;
    logic                   mode_q;
    logic [PXD_COORD_W-1:0] row_q;
    logic [PXD_COORD_W-1:0] col_q;

    // Effective position and mode of the pixel presented this cycle.
    always_comb begin
        active_o = sof_i || active_q;
        mode_o   = sof_i ? mode_i : mode_q;
        row_o    = sof_i ? '0 : row_q;
        col_o    = sof_i ? '0 : col_q;
    end

    // Advance the raster position after each accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            mode_q   <= 1'b0;
            row_q    <= '0;
            col_q    <= '0;
        end else if (valid_i && active_o) begin
            active_q <= 1'b1;
            if (sof_i) mode_q <= mode_i;
            if (col_o == LAST_COL) begin
                col_q <= '0;
                row_q <= (row_o == LAST_ROW) ? '0 : row_o + 1'b1;
            end else begin
                col_q <= col_o + 1'b1;
                row_q <= row_o;
            end
        end
    end
endmodule

// File: rtl/pxd_bias_map.sv
// Per-pixel dark-level store: one PIX_W word per raster address, cleared
// by reset. Synchronous write, combinational read of the same address.
module pxd_bias_map #(
    parameter int PIX_W   = 12,
    parameter int ENTRIES = 128,
    parameter int ADDR_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [PIX_W-1:0]  wdata_i,
    output logic [PIX_W-1:0]  rdata_o
);
    logic [PIX_W-1:0] mem [ENTRIES];

    // Clear on reset, store a bias sample on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
    end

    // Read the entry addressed by the current pixel.
    always_comb rdata_o = mem[addr_i];
endmodule

// File: rtl/pxd_event_fifo.sv
// Event queue with a sticky overflow flag. A push while full is dropped
// and sets the flag, which takes precedence over a same-cycle clear.
// A pop on an empty queue is ignored. Head is shown combinationally.
module pxd_event_fifo
    import pxd_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  pxd_event_t din_i,
    input  logic       pop_i,
    input  logic       ovf_clr_i,
    output pxd_event_t dout_o,
    output logic       valid_o,
    output logic       full_o,
    output logic       ovf_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    pxd_event_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    // Queue status and head word.
    always_comb begin
        full_o  = (count == CNT_W'(DEPTH));
        valid_o = (count != '0);
        do_push = push_i && !full_o;
        do_pop  = pop_i && valid_o;
        dout_o  = mem[rd_ptr];
    end

    // Store accepted events.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din_i;
    end

    // Pointer, occupancy and overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf_o  <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (push_i && full_o)  ovf_o <= 1'b1;
            else if (ovf_clr_i)    ovf_o <= 1'b0;
        end
    end
endmodule

// File: rtl/pixel_event_detector.sv
// Pixel threshold event detector. Tracks raster position and, per frame,
// either records a bias map or queues pixels whose bias-corrected value
// is above the threshold. Assumes one pixel at most per clock and that
// the processor drains the queue between bursts of events.
module pixel_event_detector
    import pxd_pkg::*;
#(
    parameter int COLS       = 16,
    parameter int ROWS       = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pix_valid_i,
    input  logic                   sof_i,
    input  logic [PXD_PIX_W-1:0]   pix_data_i,
    input  logic                   mode_bias_i,
    input  logic [PXD_PIX_W-1:0]   thresh_i,
    input  logic                   evt_rd_i,
    input  logic                   ovf_clr_i,
    output logic                   evt_valid_o,
    output logic [PXD_COORD_W-1:0] evt_row_o,
    output logic [PXD_COORD_W-1:0] evt_col_o,
    output logic [PXD_PIX_W-1:0]   evt_val_o,
    output logic                   ovf_o
);
    localparam int ENTRIES = COLS * ROWS;
    localparam int ADDR_W  = $clog2(ENTRIES);

    logic                   active;
    logic                   mode_bias_eff;
    logic [PXD_COORD_W-1:0] pos_row;
    logic [PXD_COORD_W-1:0] pos_col;
    logic [ADDR_W-1:0]      map_addr;
    logic [PXD_PIX_W-1:0]   bias_val;
    logic [PXD_PIX_W-1:0]   corrected;
    logic                   take;
    logic                   evt_push;
    logic                   fifo_full;
    pxd_event_t             evt_in;
    pxd_event_t             evt_head;

    pxd_raster_counter #(.COLS(COLS), .ROWS(ROWS)) u_raster (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (pix_valid_i),
        .sof_i    (sof_i),
        .mode_i   (mode_bias_i),
        .active_o (active),
        .mode_o   (mode_bias_eff),
        .row_o    (pos_row),
        .col_o    (pos_col)
    );

    // Raster address, saturating bias subtraction and threshold test.
    always_comb begin
        map_addr  = ADDR_W'(32'(pos_row) * COLS + 32'(pos_col));
        take      = pix_valid_i && active;
        corrected = (pix_data_i > bias_val) ? pix_data_i - bias_val : '0;
        evt_push  = take && !mode_bias_eff && (corrected > thresh_i);
        evt_in    = '{row: pos_row, col: pos_col, val: corrected};
    end

    pxd_bias_map #(.PIX_W(PXD_PIX_W), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_bias (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (take && mode_bias_eff),
        .addr_i  (map_addr),
        .wdata_i (pix_data_i),
        .rdata_o (bias_val)
    );

    pxd_event_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (evt_push),
        .din_i     (evt_in),
        .pop_i     (evt_rd_i),
        .ovf_clr_i (ovf_clr_i),
        .dout_o    (evt_head),
        .valid_o   (evt_valid_o),
        .full_o    (fifo_full),
        .ovf_o     (ovf_o)
    );

    // Present the head entry fields.
    always_comb begin
        evt_row_o = evt_head.row;
        evt_col_o = evt_head.col;
        evt_val_o = evt_head.val;
    end
endmodule

// File: rtl/pxd_checker.sv
// Cycle-level properties of the pixel event detector, bound to the top.
module pxd_checker #(
    parameter int COLS = 16,
    parameter int ROWS = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        pix_valid_i,
    input logic        sof_i,
    input logic [11:0] pix_data_i,
    input logic [11:0] thresh_i,
    input logic        evt_rd_i,
    input logic        ovf_clr_i,
    input logic        evt_valid_o,
    input logic [11:0] evt_val_o,
    input logic [9:0]  evt_row_o,
    input logic        ovf_o,
    input logic        active,
    input logic        mode_bias_eff,
    input logic [9:0]  pos_row,
    input logic [9:0]  pos_col,
    input logic        evt_push,
    input logic        fifo_full
);
    assert_pos_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(pos_col) < COLS) && (32'(pos_row) < ROWS));

    assert_sof_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && sof_i) |=> (!pix_valid_i || sof_i || (pos_row == 10'd0 && pos_col == 10'd1)));

    assert_quiet_before_sof_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !evt_push);

    assert_no_event_in_bias_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bias_eff |-> !evt_push);

    assert_event_above_thr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_push |-> (pix_data_i > thresh_i));

    assert_head_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_o && !evt_rd_i) |=> (evt_valid_o && $stable(evt_val_o) && $stable(evt_row_o)));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);

    assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_push && fifo_full) |=> ovf_o);

    assert_push_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_push && !fifo_full) |=> evt_valid_o);
endmodule

bind pixel_event_detector pxd_checker #(.COLS(COLS), .ROWS(ROWS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pix_valid_i   (pix_valid_i),
    .sof_i         (sof_i),
    .pix_data_i    (pix_data_i),
    .thresh_i      (thresh_i),
    .evt_rd_i      (evt_rd_i),
    .ovf_clr_i     (ovf_clr_i),
    .evt_valid_o   (evt_valid_o),
    .evt_val_o     (evt_val_o),
    .evt_row_o     (evt_row_o),
    .ovf_o         (ovf_o),
    .active        (active),
    .mode_bias_eff (mode_bias_eff),
    .pos_row       (pos_row),
    .pos_col       (pos_col),
    .evt_push      (evt_push),
    .fifo_full     (fifo_full)
);

// File: tb/sim_pixel_event_detector.sv
// Self-checking bench: reference model of raster, bias map and event queue.
module sim_pixel_event_detector;
    localparam int COLS  = 16;
    localparam int ROWS  = 8;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid_i = 1'b0;
    logic        sof_i = 1'b0;
    logic [11:0] pix_data_i = '0;
    logic        mode_bias_i = 1'b0;
    logic [11:0] thresh_i = 12'd100;
    logic        evt_rd_i = 1'b0;
    logic        ovf_clr_i = 1'b0;
    logic        evt_valid_o;
    logic [9:0]  evt_row_o;
    logic [9:0]  evt_col_o;
    logic [11:0] evt_val_o;
    logic        ovf_o;

    int tests = 0;
    int fails = 0;

    // Reference state.
    int          m_bias [COLS*ROWS];
    bit          m_active = 0;
    bit          m_mode = 0;
    int          m_row = 0;
    int          m_col = 0;
    bit          m_ovf = 0;
    logic [31:0] m_q [$];

    always #2 clk = ~clk;

    pixel_event_detector #(.COLS(COLS), .ROWS(ROWS), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid_i), .sof_i(sof_i),
        .pix_data_i(pix_data_i), .mode_bias_i(mode_bias_i), .thresh_i(thresh_i),
        .evt_rd_i(evt_rd_i), .ovf_clr_i(ovf_clr_i), .evt_valid_o(evt_valid_o),
        .evt_row_o(evt_row_o), .evt_col_o(evt_col_o), .evt_val_o(evt_val_o),
        .ovf_o(ovf_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int corr_of(input int pix, input int bias);
        return (pix > bias) ? pix - bias : 0;
    endfunction

    // Drive one pixel at a falling edge and advance the model after the rising edge.
    task automatic send_pix(input bit sof, input bit mode, input int data, input bit clr);
        int r, c, cv;
        bit md;
        pix_valid_i = 1'b1;
        sof_i       = sof;
        mode_bias_i = mode;
        pix_data_i  = 12'(data);
        ovf_clr_i   = clr;
        @(negedge clk);
        if (sof || m_active) begin
            md = sof ? mode : m_mode;
            r  = sof ? 0 : m_row;
            c  = sof ? 0 : m_col;
            if (sof) m_mode = mode;
            m_active = 1;
            if (md) m_bias[r*COLS+c] = data;
            else begin
                cv = corr_of(data, m_bias[r*COLS+c]);
                if (cv > int'(thresh_i)) begin
                    if (m_q.size() < DEPTH) m_q.push_back({10'(r), 10'(c), 12'(cv)});
                    else begin m_ovf = 1; clr = 0; end
                end
            end
            if (c == COLS-1) begin
                m_col = 0;
                m_row = (r == ROWS-1) ? 0 : r + 1;
            end else begin
                m_col = c + 1;
                m_row = r;
            end
        end
        if (clr) m_ovf = 0;
    endtask

    task automatic idle();
        pix_valid_i = 1'b0;
        sof_i       = 1'b0;
        ovf_clr_i   = 1'b0;
        @(negedge clk);
    endtask

    // Pop every queued event and compare it with the model, in order.
    task automatic drain();
        logic [31:0] exp_e;
        while (evt_valid_o) begin
            if (m_q.size() == 0) begin
                check(0, "R6 unexpected event", int'(evt_col_o), -1);
            end else begin
                exp_e = m_q.pop_front();
                check({evt_row_o, evt_col_o, evt_val_o} == exp_e, "R6 R5 event entry",
                      int'({evt_row_o, evt_col_o, evt_val_o}), int'(exp_e));
            end
            evt_rd_i = 1'b1;
            @(negedge clk);
            evt_rd_i = 1'b0;
        end
        check(m_q.size() == 0, "R6 missing events", 0, m_q.size());
    endtask

    // One random frame: mostly noise below threshold, some bright, some at the edges.
    task automatic rand_frame(input bit mode);
        int k, b, pix;
        for (int i = 0; i < COLS*ROWS; i++) begin
            b = m_bias[i];
            k = $urandom % 100;
            if (mode) pix = 100 + $urandom % 300;
            else if (k < 3) pix = b + int'(thresh_i) + 1 + $urandom % 400;
            else if (k < 6) pix = b + int'(thresh_i);
            else if (k < 8) pix = b + int'(thresh_i) + 1;
            else if (k < 12) pix = $urandom % (b + 1);
            else pix = b + $urandom % (int'(thresh_i) + 1);
            if (pix > 4095) pix = 4095;
            send_pix(i == 0, (i == 0) ? mode : 1'($urandom % 2), pix, 1'b0);
        end
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < COLS*ROWS; i++) m_bias[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(evt_valid_o == 0, "R1 fifo empty", evt_valid_o, 0);
        check(ovf_o == 0, "R1 ovf clear", ovf_o, 0);

        // R2: bright pixels before any start-of-frame are ignored.
        for (int i = 0; i < 5; i++) send_pix(1'b0, 1'b0, 4000, 1'b0);
        idle();
        check(evt_valid_o == 0, "R2 no event before sof", evt_valid_o, 0);

        // R1 and R8: zero bias map, bright origin pixel visible right after its edge.
        send_pix(1'b1, 1'b0, 500, 1'b0);
        check(evt_valid_o == 1, "R8 event visible next cycle", evt_valid_o, 1);
        check(evt_val_o == 12'd500, "R1 zero bias map", int'(evt_val_o), 500);
        for (int i = 1; i < COLS*ROWS; i++) send_pix(1'b0, 1'b0, (i == 35) ? 101 : 100, 1'b0);
        idle();
        drain();

        // R4: bias frame, mode toggled mid-frame; no events.
        rand_frame(1'b1);
        check(evt_valid_o == 0, "R4 no event in bias mode", evt_valid_o, 0);

        // R5 R6 R3 R4: random event frames over the learned bias.
        for (int f = 0; f < 6; f++) begin
            thresh_i = 12'(50 + $urandom % 200);
            rand_frame(1'b0);
            check(ovf_o == m_ovf, "R7 ovf state", ovf_o, int'(m_ovf));
            drain();
            if (m_ovf) begin
                send_pix(1'b1, 1'b1, 0, 1'b1);
                idle();
            end
        end

        // R3: restart mid-frame, then a bright pixel at (1,2) of the new frame.
        thresh_i = 12'd100;
        for (int i = 0; i < 20; i++) send_pix(i == 0, 1'b0, 0, 1'b0);
        for (int i = 0; i < COLS + 3; i++) send_pix(i == 0, 1'b0, (i == COLS + 2) ? 4095 : 0, 1'b0);
        idle();
        check(evt_row_o == 10'd1 && evt_col_o == 10'd2, "R3 restart position",
              int'({evt_row_o, evt_col_o}), (1 << 10) | 2);
        drain();

        // R7: overflow drops, sticky flag, clear, and set-beats-clear.
        for (int i = 0; i < DEPTH + 3; i++) send_pix(i == 0, 1'b0, 4095, 1'b0);
        idle();
        check(ovf_o == 1, "R7 overflow set", ovf_o, 1);
        drain();
        check(ovf_o == 1, "R7 overflow sticky after drain", ovf_o, 1);
        send_pix(1'b1, 1'b0, 0, 1'b1);
        idle();
        check(ovf_o == 0, "R7 overflow cleared", ovf_o, 0);
        for (int i = 0; i < DEPTH; i++) send_pix(i == 0, 1'b0, 4095, 1'b0);
        send_pix(1'b0, 1'b0, 4095, 1'b1);
        idle();
        check(ovf_o == 1, "R7 drop beats clear", ovf_o, 1);
        drain();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule